// File: doc/BRIEF.md
# Default-Transition Automaton Byte Scanner

The scanner walks a byte stream through a compressed deterministic automaton. Each state keeps only a short list of (byte, next-state) pairs and one default pointer. The engine searches the current state's list one entry per cycle. If the byte is not in the list, it moves along the default pointer and searches again with the same byte. The byte is accepted only once a listed transition is taken, or once a tree root runs out of entries.

A root state is complete in effect: any byte it does not list leads to the start state. Because of this, the state reached after each byte is the same state that the full 256-way automaton would reach. When that state is accepting, a match pulse carrying the state's rule tag follows one cycle later.

The table is held in several banks, selected by the low bits of the state number. It is written through a load port while no byte is offered. Three kinds of table fault end the search for the current byte: a default walk longer than the bound, a non-root state with no default pointer, and a default hop that stays in the same bank. Each fault raises an error pulse with a cause code, drops the byte and returns the engine to the start state.

Top module: `dfx_scan_top`

## Requirements
- R1: After synchronous reset, out_state is 0 and match_valid, match_tag, err, err_cause and in_ready are all 0. Every state record then reads as a root with no entries.
- R2: If entry k (counting from 0) of the current state lists the offered byte, in_ready goes high in the (k+1)-th cycle the byte is offered. After that edge, out_state equals the entry's next state.
- R3: If the offered byte is not among the current state's entries, the engine follows the default pointer and searches again with the same byte. Each state that is searched without a hit costs its entry count plus one cycles. The byte is consumed only by the state that lists it.
- R4: In the cycle after a byte is consumed, match_valid is 1 and match_tag carries the reached state's tag if that state is accepting. Otherwise both are 0, and both are always 0 after an error.
- R5: A root state that does not list the byte consumes it and moves to state 0, with no error. The cost is its entry count plus one cycles.
- R6: A walk that needs more than MAX_HOPS default hops for one byte consumes the byte. In the next cycle err is 1, err_cause is 1 and out_state is 0.
- R7: A non-root state without a default pointer that misses the byte gives err with err_cause 2. The byte is consumed and the engine returns to state 0.
- R8: The bank of a state is its number modulo NUM_BANKS. A default hop to a state in the same bank as the searching state gives err with err_cause 3. The byte is consumed and the engine returns to state 0.
- R9: Table writes issued while in_valid is high are ignored.
- R10: Header writes (wr_hdr=1: accept, tag, root, default enable, default pointer in wr_next, entry count) and entry writes (wr_hdr=0: wr_slot, wr_sym, wr_next) made while idle take effect on the following bytes.
- R11: Over any byte stream, the state and match sequence equals that of a behavioural walk of the same table.
- R12: in_ready is 0 whenever in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Offered byte |
| in_ready | output | 1 | Byte consumed at this edge |
| match_valid | output | 1 | Reached state is accepting |
| match_tag | output | TAG_W | Rule tag of the reached state |
| err | output | 1 | Table fault pulse |
| err_cause | output | 2 | 1 hop bound, 2 no default, 3 same bank |
| out_state | output | $clog2(NUM_STATES) | State after the last byte |
| wr_en | input | 1 | Table write strobe |
| wr_hdr | input | 1 | 1 header write, 0 entry write |
| wr_state | input | $clog2(NUM_STATES) | State being written |
| wr_slot | input | $clog2(MAX_TRANS) | Entry index |
| wr_sym | input | 8 | Entry byte |
| wr_next | input | $clog2(NUM_STATES) | Entry next state, or default pointer |
| wr_dflt_en | input | 1 | Default pointer present |
| wr_root | input | 1 | State is a tree root |
| wr_accept | input | 1 | State is accepting |
| wr_tag | input | TAG_W | Rule tag |
| wr_count | input | $clog2(MAX_TRANS+1) | Number of stored entries |

## Verification
The bench uses 16 states in 4 banks, at most 4 entries per state and a hop bound of 2. With these values a three-hop walk trips the bound, and a full entry list and its exhaustion cycle take only a few cycles. The table contains a two-hop walk that lands exactly on the bound, a state with no default pointer and a same-bank default hop. The per-byte latency, reached state, match tag and error cause are each compared against a behavioural walk, and so is a long stream of mixed bytes.

// File: rtl/dfx_pkg.sv
package dfx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_HOPS   = 2'd1,
    ERR_NODFLT = 2'd2,
    ERR_BANK   = 2'd3
  } dfx_err_e;
endpackage

// File: rtl/dfx_hdr_table.sv
module dfx_hdr_table #(
  parameter int NUM_STATES = 16,
  parameter int TAG_W      = 8,
  parameter int CW         = 5,
  localparam int SW        = $clog2(NUM_STATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SW-1:0]    waddr,
  input  logic             w_accept,
  input  logic [TAG_W-1:0] w_tag,
  input  logic             w_root,
  input  logic             w_den,
  input  logic [SW-1:0]    w_dflt,
  input  logic [CW-1:0]    w_cnt,
  input  logic [SW-1:0]    ra,
  output logic             ra_root,
  output logic             ra_den,
  output logic [SW-1:0]    ra_dflt,
  output logic [CW-1:0]    ra_cnt,
  input  logic [SW-1:0]    rb,
  output logic             rb_accept,
  output logic [TAG_W-1:0] rb_tag
);
  logic             acc_r  [NUM_STATES];
  logic [TAG_W-1:0] tag_r  [NUM_STATES];
  logic             root_r [NUM_STATES];
  logic             den_r  [NUM_STATES];
  logic [SW-1:0]    dflt_r [NUM_STATES];
  logic [CW-1:0]    cnt_r  [NUM_STATES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_STATES; i++) begin
        acc_r[i]  <= 1'b0;
        tag_r[i]  <= '0;
        root_r[i] <= 1'b1;
        den_r[i]  <= 1'b0;
        dflt_r[i] <= '0;
        cnt_r[i]  <= '0;
      end
    end else if (we) begin
      acc_r[waddr]  <= w_accept;
      tag_r[waddr]  <= w_tag;
      root_r[waddr] <= w_root;
      den_r[waddr]  <= w_den;
      dflt_r[waddr] <= w_dflt;
      cnt_r[waddr]  <= w_cnt;
    end
  end

  assign ra_root   = root_r[ra];
  assign ra_den    = den_r[ra];
  assign ra_dflt   = dflt_r[ra];
  assign ra_cnt    = cnt_r[ra];
  assign rb_accept = acc_r[rb];
  assign rb_tag    = tag_r[rb];
endmodule

// File: rtl/dfx_trans_bank.sv
module dfx_trans_bank #(
  parameter int DEPTH = 64,
  parameter int NW    = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    w_sym,
  input  logic [NW-1:0] w_next,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    r_sym,
  output logic [NW-1:0] r_next
);
  logic [7:0]    sym_m [DEPTH];
  logic [NW-1:0] nxt_m [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      sym_m[waddr] <= w_sym;
      nxt_m[waddr] <= w_next;
    end
  end

  assign r_sym  = sym_m[raddr];
  assign r_next = nxt_m[raddr];
endmodule

// File: rtl/dfx_walker.sv
module dfx_walker
  import dfx_pkg::*;
#(
  parameter int NUM_STATES = 16,
  parameter int NUM_BANKS  = 4,
  parameter int MAX_TRANS  = 16,
  parameter int MAX_HOPS   = 4,
  parameter int TAG_W      = 8,
  localparam int SW        = $clog2(NUM_STATES),
  localparam int BW        = $clog2(NUM_BANKS),
  localparam int CW        = $clog2(MAX_TRANS + 1),
  localparam int HW        = $clog2(MAX_HOPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             match_valid,
  output logic [TAG_W-1:0] match_tag,
  output logic             err,
  output logic [1:0]       err_cause,
  output logic [SW-1:0]    out_state,
  output logic [SW-1:0]    look_state,
  output logic [CW-1:0]    slot_idx,
  output logic [HW-1:0]    hop_cnt,
  output logic             hop_evt,
  output logic             err_evt,
  input  logic             l_root,
  input  logic             l_den,
  input  logic [SW-1:0]    l_dflt,
  input  logic [CW-1:0]    l_cnt,
  input  logic [7:0]       e_sym,
  input  logic [SW-1:0]    e_next,
  output logic [SW-1:0]    nxt_state,
  input  logic             n_accept,
  input  logic [TAG_W-1:0] n_tag
);
  localparam logic [SW-1:0] START = '0;
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_TRANS);
  localparam logic [HW-1:0] HOP_MAX = HW'(MAX_HOPS);

  function automatic logic [BW-1:0] bank_of(input logic [SW-1:0] s);
    return s[BW-1:0];
  endfunction

  function automatic logic [CW-1:0] clamp_cnt(input logic [CW-1:0] c);
    return (c > CNT_MAX) ? CNT_MAX : c;
  endfunction

  logic [SW-1:0] cur_q, look_q;
  logic [CW-1:0] idx_q;
  logic [HW-1:0] hops_q;
  logic          slot_live, hit, exh, root_miss, need_hop, take;
  dfx_err_e      code;

  always_comb begin
    slot_live = idx_q < clamp_cnt(l_cnt);
    hit       = in_valid && slot_live && (e_sym == in_byte);
    exh       = in_valid && !slot_live;
    root_miss = exh && l_root;
    need_hop  = exh && !l_root;
    if (!need_hop)                            code = ERR_NONE;
    else if (!l_den)                          code = ERR_NODFLT;
    else if (hops_q >= HOP_MAX)               code = ERR_HOPS;
    else if (bank_of(l_dflt) == bank_of(look_q)) code = ERR_BANK;
    else                                      code = ERR_NONE;
    err_evt   = need_hop && (code != ERR_NONE);
    hop_evt   = need_hop && (code == ERR_NONE);
    take      = hit || root_miss || err_evt;
    nxt_state = hit ? e_next : START;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= START;
      look_q      <= START;
      idx_q       <= '0;
      hops_q      <= '0;
      match_valid <= 1'b0;
      match_tag   <= '0;
      err         <= 1'b0;
      err_cause   <= ERR_NONE;
    end else begin
      match_valid <= (hit || root_miss) && n_accept;
      match_tag   <= ((hit || root_miss) && n_accept) ? n_tag : '0;
      err         <= err_evt;
      err_cause   <= err_evt ? code : ERR_NONE;
      if (!in_valid) begin
        look_q <= cur_q;
        idx_q  <= '0;
        hops_q <= '0;
      end else if (take) begin
        cur_q  <= nxt_state;
        look_q <= nxt_state;
        idx_q  <= '0;
        hops_q <= '0;
      end else if (hop_evt) begin
        look_q <= l_dflt;
        idx_q  <= '0;
        hops_q <= hops_q + 1'b1;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign in_ready   = take;
  assign out_state  = cur_q;
  assign look_state = look_q;
  assign slot_idx   = idx_q;
  assign hop_cnt    = hops_q;
endmodule

// File: rtl/dfx_scan_top.sv
module dfx_scan_top #(
  parameter int NUM_STATES = 16,
  parameter int NUM_BANKS  = 4,
  parameter int MAX_TRANS  = 16,
  parameter int MAX_HOPS   = 4,
  parameter int TAG_W      = 8,
  localparam int SW        = $clog2(NUM_STATES),
  localparam int BW        = $clog2(NUM_BANKS),
  localparam int TIW       = $clog2(MAX_TRANS),
  localparam int CW        = $clog2(MAX_TRANS + 1),
  localparam int HW        = $clog2(MAX_HOPS + 1),
  localparam int ROWS      = NUM_STATES / NUM_BANKS,
  localparam int BDEPTH    = ROWS << TIW,
  localparam int BAW       = $clog2(BDEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             match_valid,
  output logic [TAG_W-1:0] match_tag,
  output logic             err,
  output logic [1:0]       err_cause,
  output logic [SW-1:0]    out_state,
  input  logic             wr_en,
  input  logic             wr_hdr,
  input  logic [SW-1:0]    wr_state,
  input  logic [TIW-1:0]   wr_slot,
  input  logic [7:0]       wr_sym,
  input  logic [SW-1:0]    wr_next,
  input  logic             wr_dflt_en,
  input  logic             wr_root,
  input  logic             wr_accept,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [CW-1:0]    wr_count
);
  function automatic logic [BAW-1:0] row_addr(input logic [SW-1:0] s,
                                              input logic [TIW-1:0] slot);
    return {s[SW-1:BW], slot};
  endfunction

  logic             wr_ok;
  logic [SW-1:0]    look_state, nxt_state;
  logic [CW-1:0]    slot_idx;
  logic [HW-1:0]    hop_cnt;
  logic             hop_evt, err_evt;
  logic             l_root, l_den, n_accept;
  logic [SW-1:0]    l_dflt, e_next;
  logic [CW-1:0]    l_cnt;
  logic [TAG_W-1:0] n_tag;
  logic [7:0]       e_sym;
  logic [7:0]       bk_sym  [NUM_BANKS];
  logic [SW-1:0]    bk_next [NUM_BANKS];
  logic [BAW-1:0]   rd_addr;

  assign wr_ok   = wr_en && !in_valid;
  assign rd_addr = row_addr(look_state, slot_idx[TIW-1:0]);

  dfx_hdr_table #(.NUM_STATES(NUM_STATES), .TAG_W(TAG_W), .CW(CW)) u_hdr (
    .clk(clk), .rst(rst), .we(wr_ok && wr_hdr), .waddr(wr_state),
    .w_accept(wr_accept), .w_tag(wr_tag), .w_root(wr_root),
    .w_den(wr_dflt_en), .w_dflt(wr_next), .w_cnt(wr_count),
    .ra(look_state), .ra_root(l_root), .ra_den(l_den), .ra_dflt(l_dflt),
    .ra_cnt(l_cnt), .rb(nxt_state), .rb_accept(n_accept), .rb_tag(n_tag)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dfx_trans_bank #(.DEPTH(BDEPTH), .NW(SW)) u_bank (
      .clk(clk),
      .we(wr_ok && !wr_hdr && (wr_state[BW-1:0] == BW'(b))),
      .waddr(row_addr(wr_state, wr_slot)),
      .w_sym(wr_sym), .w_next(wr_next),
      .raddr(rd_addr), .r_sym(bk_sym[b]), .r_next(bk_next[b])
    );
  end

  assign e_sym  = bk_sym[look_state[BW-1:0]];
  assign e_next = bk_next[look_state[BW-1:0]];

  dfx_walker #(
    .NUM_STATES(NUM_STATES), .NUM_BANKS(NUM_BANKS), .MAX_TRANS(MAX_TRANS),
    .MAX_HOPS(MAX_HOPS), .TAG_W(TAG_W)
  ) u_walk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .match_valid(match_valid), .match_tag(match_tag),
    .err(err), .err_cause(err_cause), .out_state(out_state),
    .look_state(look_state), .slot_idx(slot_idx), .hop_cnt(hop_cnt),
    .hop_evt(hop_evt), .err_evt(err_evt),
    .l_root(l_root), .l_den(l_den), .l_dflt(l_dflt), .l_cnt(l_cnt),
    .e_sym(e_sym), .e_next(e_next), .nxt_state(nxt_state),
    .n_accept(n_accept), .n_tag(n_tag)
  );
endmodule

// File: rtl/dfx_scan_chk.sv
module dfx_scan_chk #(
  parameter int NUM_STATES = 16,
  parameter int NUM_BANKS  = 4,
  parameter int MAX_HOPS   = 4,
  localparam int SW        = $clog2(NUM_STATES),
  localparam int BW        = $clog2(NUM_BANKS),
  localparam int HW        = $clog2(MAX_HOPS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          match_valid,
  input logic          err,
  input logic [SW-1:0] out_state,
  input logic [SW-1:0] look_state,
  input logic [HW-1:0] hop_cnt,
  input logic          hop_evt
);
  logic [BW-1:0] look_bank;
  assign look_bank = look_state[BW-1:0];

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> in_valid); // R12
  AST_MATCH_AFTER_CONSUME: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(in_ready)); // R4
  AST_NO_MATCH_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    err |-> !match_valid); // R4
  AST_ERR_TO_START: assert property (@(posedge clk) disable iff (rst)
    err |-> (out_state == '0)); // R6
  AST_HOP_BOUND: assert property (@(posedge clk) disable iff (rst)
    hop_cnt <= HW'(MAX_HOPS)); // R6
  AST_BANK_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    hop_evt |=> (look_bank != $past(look_bank))); // R8
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(in_ready) |-> $stable(out_state)); // R2
endmodule

bind dfx_scan_top dfx_scan_chk #(
  .NUM_STATES(NUM_STATES), .NUM_BANKS(NUM_BANKS), .MAX_HOPS(MAX_HOPS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .match_valid(match_valid), .err(err), .out_state(out_state),
  .look_state(look_state), .hop_cnt(hop_cnt), .hop_evt(hop_evt)
);

// File: tb/dfx_scan_tb.sv
module dfx_scan_top_tb_top;
  localparam int NS = 16, NB = 4, MT = 4, MH = 2, TW = 4;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [7:0] in_byte;
  logic in_ready, match_valid, err;
  logic [TW-1:0] match_tag;
  logic [1:0] err_cause;
  logic [3:0] out_state;
  logic wr_en, wr_hdr, wr_dflt_en, wr_root, wr_accept;
  logic [3:0] wr_state, wr_next;
  logic [1:0] wr_slot;
  logic [7:0] wr_sym;
  logic [TW-1:0] wr_tag;
  logic [2:0] wr_count;

  dfx_scan_top #(.NUM_STATES(NS), .NUM_BANKS(NB), .MAX_TRANS(MT),
                 .MAX_HOPS(MH), .TAG_W(TW)) dut_i (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int m_acc[NS], m_tag[NS], m_root[NS], m_den[NS], m_dflt[NS], m_cnt[NS];
  int m_sym[NS][MT], m_nxt[NS][MT];
  int m_cur = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: run hung act=%0d exp<=%0d", cyc, 100000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic hdr_w(input int s, input int acc, input int tg, input int root,
                       input int den, input int dflt, input int cnt);
    @(negedge clk);
    wr_en = 1; wr_hdr = 1; wr_state = 4'(s); wr_accept = acc[0];
    wr_tag = TW'(tg); wr_root = root[0]; wr_dflt_en = den[0];
    wr_next = 4'(dflt); wr_count = 3'(cnt);
    @(negedge clk);
    wr_en = 0;
    m_acc[s] = acc; m_tag[s] = tg; m_root[s] = root; m_den[s] = den;
    m_dflt[s] = dflt; m_cnt[s] = cnt;
  endtask

  task automatic tr_w(input int s, input int k, input int sym, input int nx);
    @(negedge clk);
    wr_en = 1; wr_hdr = 0; wr_state = 4'(s); wr_slot = 2'(k);
    wr_sym = 8'(sym); wr_next = 4'(nx);
    @(negedge clk);
    wr_en = 0;
    m_sym[s][k] = sym; m_nxt[s][k] = nx;
  endtask

  // Behavioural walk: returns next state, error cause, and cycle cost.
  task automatic model(input int b, output int nx, output int ec, output int lat);
    int s = m_cur, h = 0;
    lat = 0; ec = 0; nx = 0;
    forever begin
      for (int k = 0; k < m_cnt[s]; k++) begin
        lat++;
        if (m_sym[s][k] == b) begin nx = m_nxt[s][k]; return; end
      end
      lat++;
      if (m_root[s] != 0) begin nx = 0; return; end
      if (m_den[s] == 0) begin ec = 2; return; end
      if (h >= MH) begin ec = 1; return; end
      if ((m_dflt[s] % NB) == (s % NB)) begin ec = 3; return; end
      s = m_dflt[s];
      h++;
    end
  endtask

  task automatic send(input int b, input string req, input bit wr_during);
    int nx, ec, lat, waits, ex_mv, ex_tag;
    model(b, nx, ec, lat);
    @(negedge clk);
    in_valid = 1; in_byte = 8'(b);
    if (wr_during) begin
      wr_en = 1; wr_hdr = 1; wr_state = 0; wr_count = 0; wr_root = 1;
      wr_dflt_en = 0; wr_accept = 1; wr_tag = 4'hf; wr_next = 0;
    end
    #1;
    waits = 0;
    while (!in_ready && waits < 200) begin
      chk(!match_valid && !err, req, "no output while searching", match_valid, 0);
      waits++;
      @(negedge clk); #1;
    end
    chk(waits + 1 == lat, req, "latency cycles", waits + 1, lat);
    @(negedge clk);
    in_valid = 0; wr_en = 0;
    #1;
    ex_mv  = (ec == 0) ? m_acc[nx] : 0;
    ex_tag = (ex_mv != 0) ? m_tag[nx] : 0;
    chk(out_state == 4'(nx), req, "out_state", out_state, nx);
    chk(match_valid == ex_mv[0], req, "match_valid", match_valid, ex_mv);
    chk(match_tag == TW'(ex_tag), req, "match_tag", match_tag, ex_tag);
    chk(err == (ec != 0), req, "err", err, ec != 0);
    chk(err_cause == 2'(ec), req, "err_cause", err_cause, ec);
    m_cur = nx;
  endtask

  initial begin
    int seed = 7;
    byte alpha[8] = '{8'h61, 8'h62, 8'h63, 8'h64, 8'h78, 8'h79, 8'h7a, 8'h71};
    for (int i = 0; i < NS; i++) begin
      m_acc[i] = 0; m_tag[i] = 0; m_root[i] = 1; m_den[i] = 0;
      m_dflt[i] = 0; m_cnt[i] = 0;
    end
    rst = 1; in_valid = 0; in_byte = 0; wr_en = 0; wr_hdr = 0; wr_state = 0;
    wr_slot = 0; wr_sym = 0; wr_next = 0; wr_dflt_en = 0; wr_root = 0;
    wr_accept = 0; wr_tag = 0; wr_count = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(out_state == 0 && !match_valid && match_tag == 0 && !err && err_cause == 0,
        "R1", "reset outputs", {out_state, match_valid, err}, 0);
    chk(!in_ready, "R12", "ready idle", in_ready, 0);
    send(8'h61, "R1", 0); // empty root table: any byte -> state 0, cost 1

    // Table: state number modulo 4 is the bank.
    hdr_w(0, 0, 0, 1, 0, 0, 4);
    tr_w(0, 0, 8'h61, 1); tr_w(0, 1, 8'h62, 2);
    tr_w(0, 2, 8'h63, 3); tr_w(0, 3, 8'h64, 7);
    hdr_w(1, 1, 1, 0, 1, 0, 1); tr_w(1, 0, 8'h78, 5);
    hdr_w(2, 1, 2, 0, 1, 1, 1); tr_w(2, 0, 8'h79, 6);
    hdr_w(3, 0, 0, 0, 1, 2, 0);
    hdr_w(5, 1, 5, 0, 1, 0, 0);
    hdr_w(6, 0, 0, 0, 0, 0, 1); tr_w(6, 0, 8'h7a, 0);
    hdr_w(7, 0, 0, 0, 1, 11, 0);
    chk(1, "R10", "table loaded while idle", 1, 1);

    send(8'h61, "R2", 0);  // 0 -> 1, accepting tag 1
    send(8'h78, "R4", 0);  // 1 -> 5, tag 5
    send(8'h62, "R3", 0);  // 5 misses, default to 0, hit b -> 2
    send(8'h79, "R4", 0);  // 2 -> 6, not accepting
    send(8'h71, "R7", 0);  // 6 has no default
    send(8'h64, "R2", 0);  // last entry of 0 -> 7
    send(8'h61, "R8", 0);  // 7 defaults into bank 3 again
    send(8'h63, "R2", 0);  // 0 -> 3
    send(8'h61, "R6", 0);  // 3 -> 2 -> 1 -> needs third hop
    send(8'h63, "R2", 0);
    send(8'h78, "R3", 0);  // two hops, at the bound, -> 5
    send(8'h62, "R3", 0);
    send(8'h61, "R3", 0);  // 2 -> 1 -> 0, hit a
    send(8'h71, "R3", 0);  // 1 -> 0 root miss
    send(8'h71, "R5", 0);  // root miss at 0
    send(8'h71, "R9", 1);  // header write to state 0 during valid, ignored
    send(8'h61, "R9", 0);  // still 0 -> 1
    @(negedge clk); #1;
    chk(!in_ready, "R12", "ready idle after byte", in_ready, 0);

    hdr_w(5, 1, 5, 0, 1, 0, 1); tr_w(5, 0, 8'h6b, 3);
    send(8'h78, "R10", 0); // 1 -> 5
    send(8'h6b, "R10", 0); // new entry: 5 -> 3

    for (int i = 0; i < 200; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      send(int'(alpha[(seed >> 8) % 8]), "R11", 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule